// File: doc/BRIEF.md
# Rectifying Leaky-Integrator Envelope Detector

This block tracks the envelope of a stream of signed samples. Every accepted sample is folded into a first-order leaky accumulator. A negative sample is subtracted and a non-negative one is added, so the accumulator builds up the absolute value without a separate rectifier stage. Before the new magnitude goes in, the accumulator gives up a share of itself equal to the accumulator shifted right by a build-time amount. The result is a low-pass filtered magnitude that settles near two-to-the-shift times the mean absolute input.

The leak shift is a parameter. A larger shift lowers the cutoff for a given sample rate. A second parameter can drop low-order bits from the presented value, which gives a scaled output. The accumulator is sized so that a sustained full-scale input cannot wrap it.

The output is registered. Each accepted sample produces exactly one output strobe, one clock after the accumulator update.

Top module: `envelope_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator is cleared to zero. After the following edge, `env_o` is 0 and `env_valid_o` is 0.
- R2: On each accepted sample, the accumulator first loses floor(acc / 2^LEAK_SHIFT), with LEAK_SHIFT = 6 by default. With a zero sample and acc >= 2^LEAK_SHIFT, the accumulator strictly decreases.
- R3: The sample is read as two's complement. If bit DATA_W-1 is 1, the sample is subtracted from the leaked accumulator; otherwise it is added. The new value is acc - (acc >> LEAK_SHIFT) + |sample|.
- R4: The most negative input (-2^(DATA_W-1)) adds exactly 2^(DATA_W-1). A sustained run of that value never wraps the accumulator, and its top bit stays 0.
- R5: On a clock where `in_valid_i` is 0 (and reset is high), the accumulator keeps its value, `in_sample_i` has no effect, and `env_o` does not change.
- R6: `env_valid_o` is 1 in exactly the clock after each clock in which a sample was accepted, and 0 otherwise.
- R7: `env_o` shows the accumulator shifted right by OUT_SHIFT, with OUT_SHIFT = 0 by default (the raw accumulator), as the value after the accepted sample.
- R8: When reset and a valid sample fall in the same clock, reset wins: the sample is discarded and no output strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Marks `in_sample_i` as a sample to accept this clock |
| in_sample_i | input | DATA_W | Signed two's-complement sample |
| env_valid_o | output | 1 | Strobe: `env_o` holds a new value |
| env_o | output | ACC_W-OUT_SHIFT | Envelope estimate (accumulator >> OUT_SHIFT) |

## Verification
Two events can land in the same clock: a reset and a valid sample (including the most negative value). The bench builds up a non-zero accumulator, then drives `rst_n` low while `in_valid_i` is high with a large negative sample. It expects `env_o` to return to zero and no strobe to follow. A back-to-back stream with valid held high also checks that the leak and the rectified add combine in one update, against values worked out by hand.

// File: rtl/envelope_tracker_pkg.sv
// Package: shared defaults for the envelope tracker.
// Assumes: nothing beyond the parameters listed here.
package envelope_tracker_pkg;
    localparam int unsigned DEF_DATA_W     = 16;
    localparam int unsigned DEF_LEAK_SHIFT = 6;
    localparam int unsigned DEF_OUT_SHIFT  = 0;
    // Headroom: steady state is about 2^(DATA_W-1+LEAK_SHIFT); one spare bit on top.
    function automatic int unsigned acc_width(input int unsigned data_w, input int unsigned leak_shift);
        return data_w + leak_shift + 1;
    endfunction
endpackage

// File: rtl/envelope_step.sv
// Module: envelope_step
// Combinational update: leak by a right shift, then add the rectified sample.
// Assumes: ACC_W > DATA_W, and acc_i keeps its top bit clear (guaranteed by sizing).
module envelope_step #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned LEAK_SHIFT = 6,
    parameter int unsigned ACC_W      = 23
) (
    input  logic [ACC_W-1:0]         acc_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic [ACC_W-1:0]         acc_next_o
);
    logic [ACC_W-1:0] sample_ext;
    logic [ACC_W-1:0] leak_amt;
    logic             is_neg;

    // Purpose: sign-extend, take the leak, then add or subtract by sign.
    always_comb begin
        sample_ext = ACC_W'(sample_i);
        is_neg     = sample_i[DATA_W-1];
        leak_amt   = acc_i >> LEAK_SHIFT;
        if (is_neg) begin
            acc_next_o = acc_i - leak_amt - sample_ext;
        end else begin
            acc_next_o = acc_i - leak_amt + sample_ext;
        end
    end
endmodule

// File: rtl/envelope_out_stage.sv
// Module: envelope_out_stage
// Registers the scaled accumulator and a one-clock strobe after each update.
// Assumes: upd_i is high in the clock where the accumulator was just written.
module envelope_out_stage #(
    parameter int unsigned ACC_W     = 23,
    parameter int unsigned OUT_SHIFT = 0,
    localparam int unsigned OUT_W    = ACC_W - OUT_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] env_o
);
    logic [OUT_W-1:0] scaled;

    generate
        if (OUT_SHIFT == 0) begin : g_raw
            assign scaled = acc_i;
        end else begin : g_scaled
            assign scaled = acc_i[ACC_W-1:OUT_SHIFT];
        end
    endgenerate

    // Purpose: capture the envelope and raise the strobe after each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            env_o   <= '0;
        end else begin
            valid_o <= upd_i;
            if (upd_i) begin
                env_o <= scaled;
            end
        end
    end

    p_strobe_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> !valid_o);
endmodule

// File: rtl/envelope_tracker.sv
// Module: envelope_tracker (top)
// Leaky rectifying integrator: acc <= acc - (acc >> LEAK_SHIFT) + |sample| on each valid sample.
// Assumes: synchronous active-low reset; samples are two's complement.
module envelope_tracker
    import envelope_tracker_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LEAK_SHIFT = DEF_LEAK_SHIFT,
    parameter int unsigned OUT_SHIFT  = DEF_OUT_SHIFT,
    localparam int unsigned ACC_W     = acc_width(DATA_W, LEAK_SHIFT),
    localparam int unsigned OUT_W     = ACC_W - OUT_SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_i,
    input  logic signed [DATA_W-1:0] in_sample_i,
    output logic                     env_valid_o,
    output logic [OUT_W-1:0]         env_o
);
    localparam logic [ACC_W-1:0] LEAK_FLOOR = ACC_W'(1) << LEAK_SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             upd_q;

    envelope_step #(
        .DATA_W(DATA_W), .LEAK_SHIFT(LEAK_SHIFT), .ACC_W(ACC_W)
    ) u_step (
        .acc_i(acc_q), .sample_i(in_sample_i), .acc_next_o(acc_d)
    );

    // Purpose: hold the accumulator, writing it only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= in_valid_i;
            if (in_valid_i) begin
                acc_q <= acc_d;
            end
        end
    end

    envelope_out_stage #(
        .ACC_W(ACC_W), .OUT_SHIFT(OUT_SHIFT)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_q), .acc_i(acc_q),
        .valid_o(env_valid_o), .env_o(env_o)
    );

    p_reset_r1 : assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0) && !upd_q);
    p_decay_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_sample_i == '0 && acc_q >= LEAK_FLOOR) |=> acc_q < $past(acc_q));
    p_rect_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_sample_i != '0 && acc_q < LEAK_FLOOR) |=> acc_q > $past(acc_q));
    p_no_overflow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[ACC_W-1] == 1'b0);
    p_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(acc_q));
    p_strobe_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> upd_q);
endmodule

// File: tb/envelope_tracker_tb.sv
module envelope_tracker_tb;
    localparam int DW = 16;
    localparam int AW = 23;
    localparam int NV = 6;
    // {sample, expected accumulator after it}, starting from zero
    localparam logic [DW+AW-1:0] VEC [NV] = '{
        {16'sd100,    23'd100},
        {-16'sd200,   23'd299},
        {16'h8000,    23'd33063},
        {16'sd0,      23'd32547},
        {16'sd32767,  23'd64806},
        {-16'sd1,     23'd63795}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic env_valid;
    logic [AW-1:0] env;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    envelope_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_sample_i(in_sample),
        .env_valid_o(env_valid), .env_o(env)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        longint model;
        logic [AW-1:0] held;
        repeat (3) @(negedge clk);
        chk("R1 env after reset", env, 0);
        chk("R1 strobe after reset", env_valid, 0);
        rst_n = 1'b1;

        // Table: back-to-back stream (R2, R3, R4, R7)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R6 strobe in stream", env_valid, 1);
                chk("R2/R3 R7 env value", env, VEC[i-2][AW-1:0]);
            end
            if (i < NV) begin
                in_valid = 1'b1;
                in_sample = VEC[i][DW+AW-1:AW];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R6 strobe drops", env_valid, 0);

        // R5: invalid samples ignored
        held = env;
        in_valid = 1'b0;
        in_sample = 16'h8000;
        repeat (4) @(negedge clk);
        chk("R5 env held", env, held);
        chk("R5 no strobe", env_valid, 0);
        in_valid = 1'b1;
        in_sample = 16'sd0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R5 state kept across gap", env, 63795 - (63795 >> 6));

        // R4: sustained most negative input, model from R3
        model = 63795 - (63795 >> 6);
        in_valid = 1'b1;
        in_sample = 16'h8000;
        for (int k = 0; k < 3000; k++) begin
            model = model - (model >> 6) + 32768;
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R4 full-scale negative run", env, model);
        chk("R4 top bit clear", env[AW-1], 0);

        // R8: reset and valid sample in the same clock
        in_valid = 1'b1;
        in_sample = -16'sd30000;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 env cleared", env, 0);
        chk("R8 no strobe", env_valid, 0);

        // R3: single positive sample from zero with OUT_SHIFT 0 (R7)
        in_valid = 1'b1;
        in_sample = 16'sd7;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R3 positive add", env, 7);
        chk("R6 single strobe", env_valid, 1);
        @(negedge clk);
        chk("R6 strobe one clock only", env_valid, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule